// File: doc/BRIEF.md
# SDRAM Low-Power Mode Access Gate

This block sits between a bus-side request port and the static and dynamic back ends of an external memory controller. Each request address is decoded to one of four static chip selects (16 MB windows) or one of four dynamic chip selects (256 MB windows). The block then decides whether the request goes through, must wait, or ends in a bus error, according to the low-power state of the SDRAM.

Software controls the low-power states through four control inputs. One is a self-refresh request bit, acknowledged through `sr_ack`. The other three are a deep-sleep bit, a dynamic clock-enable bit and a dynamic clock-control bit, and deep power-down starts only when all three are set. The controller has five states. NORMAL is the idle, open state. ENTERING_SR drains any dynamic transfer in flight. SELF_REFRESH and DEEP_PD are closed states. EXITING_SR is a programmable recovery window. On each state change the block sends a one-cycle command code to the SDRAM sequencer.

Transitions: NORMAL goes to ENTERING_SR when self-refresh is requested or deep power-down is armed. ENTERING_SR waits for the back end to go idle. It then moves to DEEP_PD if deep power-down is armed, otherwise to SELF_REFRESH if self-refresh is still requested, otherwise back to NORMAL. SELF_REFRESH goes to DEEP_PD if deep power-down is armed, or to EXITING_SR when the request is cleared. DEEP_PD goes to EXITING_SR when the deep-sleep bit is cleared. EXITING_SR returns to NORMAL when its hold counter reaches zero.

Top module: `sdram_lp_gate`

## Requirements
- R1: After reset the block is in NORMAL. `sr_ack` is 0, `seq_cmd` is 0 (no command), and with no request no chip select, wait or error is asserted.
- R2: An address whose bits [31:26] are 6'b100000 selects static chip select `cs_stat[addr[25:24]]` in every state, with no error and no wait.
- R3: An address whose bits [31:28] are 0xA, 0xB, 0xC or 0xD selects dynamic chip select `cs_dyn[addr[31:28]-0xA]` while the state is NORMAL.
- R4: An address outside all eight windows asserts no chip select and raises `bus_err` in every state.
- R5: When the self-refresh request is set, the block enters ENTERING_SR on the next edge. It moves to SELF_REFRESH on the first edge at which `dyn_busy` is low. On that edge `seq_cmd` becomes 1 (enter self-refresh) and `sr_ack` becomes 1.
- R6: In ENTERING_SR and EXITING_SR, a dynamic-window request raises `req_wait` and asserts neither a chip select nor `bus_err`.
- R7: In SELF_REFRESH, a dynamic-window request raises `bus_err` and asserts no dynamic chip select.
- R8: Static-window requests are served while the dynamic memory is in SELF_REFRESH or DEEP_PD.
- R9: Clearing the self-refresh request in SELF_REFRESH moves the block to EXITING_SR on the next edge, with `seq_cmd`=2 (exit self-refresh) and `sr_ack`=0. Dynamic requests then wait for `exit_hold`+1 cycles before the gate reopens.
- R10: Deep power-down is armed only when the deep-sleep, clock-enable and clock-control bits are all 1. Entry drives `seq_cmd`=3. In DEEP_PD, dynamic requests raise `bus_err`. Clearing the deep-sleep bit moves the block to EXITING_SR with `seq_cmd`=4.
- R11: A command code lasts one cycle. Otherwise `seq_cmd` is 0.
- R12: When self-refresh is requested and deep power-down is armed at the same time, deep power-down wins. `sr_ack` stays 0.
- R13: If the self-refresh request is withdrawn while the block is in ENTERING_SR, the block returns to NORMAL with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Self-refresh request control bit |
| dp_bit | input | 1 | Deep-sleep control bit |
| clk_en_bit | input | 1 | Dynamic clock-enable control bit |
| clk_ctl_bit | input | 1 | Dynamic clock-control bit |
| exit_hold | input | HOLD_W | Recovery cycles minus one after leaving a low-power state |
| dyn_busy | input | 1 | Dynamic back end has a transfer in flight |
| req_valid | input | 1 | Bus request present |
| req_addr | input | ADDR_W | Bus request address |
| cs_stat | output | NCS | Static chip selects, one-hot |
| cs_dyn | output | NCS | Dynamic chip selects, one-hot |
| req_wait | output | 1 | Dynamic request held off; retry |
| bus_err | output | 1 | Request refused with an error response |
| sr_ack | output | 1 | Self-refresh acknowledge status |
| seq_cmd | output | 3 | Command to the SDRAM sequencer (0 none, 1 SR enter, 2 SR exit, 3 DPD enter, 4 DPD exit) |

## Verification
Random addresses are drawn from static windows, dynamic windows and unmapped space. They are decoded first in NORMAL and then in SELF_REFRESH, which separates decode faults from gating faults. Directed sequences then cover the remaining cases. Entry is held back by a busy back end. Recovery is counted cycle by cycle. Deep power-down is armed with only two of its three bits, which must be ignored. A simultaneous self-refresh and deep-power-down request checks the priority. A request withdrawn during draining checks that the block falls back to NORMAL.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [2:0] {
        NORMAL       = 3'd0,
        ENTERING_SR  = 3'd1,
        SELF_REFRESH = 3'd2,
        EXITING_SR   = 3'd3,
        DEEP_PD      = 3'd4
    } lp_state_e;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_SR_ENTER  = 3'd1,
        CMD_SR_EXIT   = 3'd2,
        CMD_DPD_ENTER = 3'd3,
        CMD_DPD_EXIT  = 3'd4
    } lp_cmd_e;

endpackage

// File: rtl/lp_addr_decode.sv
module lp_addr_decode #(
    parameter int              AW         = 32,
    parameter int              NCS        = 4,
    parameter logic [AW-1:0]   STAT_BASE  = 32'h8000_0000,
    parameter int              STAT_SHIFT = 24,
    parameter logic [AW-1:0]   DYN_BASE   = 32'hA000_0000,
    parameter int              DYN_SHIFT  = 28
) (
    input  logic [AW-1:0]  addr,
    output logic [NCS-1:0] hit_stat,
    output logic [NCS-1:0] hit_dyn
);

    localparam logic [AW-1:0] STAT_TAG = STAT_BASE >> STAT_SHIFT;
    localparam logic [AW-1:0] DYN_TAG  = DYN_BASE >> DYN_SHIFT;

    logic [AW-1:0] stat_key;
    logic [AW-1:0] dyn_key;

    assign stat_key = addr >> STAT_SHIFT;
    assign dyn_key  = addr >> DYN_SHIFT;

    for (genvar i = 0; i < NCS; i++) begin : g_win
        assign hit_stat[i] = (stat_key == STAT_TAG + AW'(i));
        assign hit_dyn[i]  = (dyn_key  == DYN_TAG  + AW'(i));
    end

    // windows never overlap: at most one select may hit (R2, R3)
    always_comb begin
        assert_decode_onehot_R2: assert ($onehot0({hit_stat, hit_dyn}));
    end

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
    import sdram_lp_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_req,
    input  logic              dp_bit,
    input  logic              dpd_arm,
    input  logic              dyn_busy,
    input  logic [HOLD_W-1:0] exit_hold,
    output lp_state_e         state,
    output lp_cmd_e           cmd
);

    lp_state_e         nxt;
    lp_cmd_e           nxt_cmd;
    logic [HOLD_W-1:0] cnt;

    always_comb begin
        nxt     = state;
        nxt_cmd = CMD_NONE;
        unique case (state)
            NORMAL: begin
                if (sr_req || dpd_arm) nxt = ENTERING_SR;
            end
            ENTERING_SR: begin
                if (!dyn_busy) begin
                    if (dpd_arm) begin
                        nxt     = DEEP_PD;
                        nxt_cmd = CMD_DPD_ENTER;
                    end else if (sr_req) begin
                        nxt     = SELF_REFRESH;
                        nxt_cmd = CMD_SR_ENTER;
                    end else begin
                        nxt = NORMAL;
                    end
                end
            end
            SELF_REFRESH: begin
                if (dpd_arm) begin
                    nxt     = DEEP_PD;
                    nxt_cmd = CMD_DPD_ENTER;
                end else if (!sr_req) begin
                    nxt     = EXITING_SR;
                    nxt_cmd = CMD_SR_EXIT;
                end
            end
            EXITING_SR: begin
                if (cnt == '0) nxt = NORMAL;
            end
            DEEP_PD: begin
                if (!dp_bit) begin
                    nxt     = EXITING_SR;
                    nxt_cmd = CMD_DPD_EXIT;
                end
            end
            default: nxt = NORMAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= NORMAL;
        else        state <= nxt;
    end

    // registered outputs and recovery counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd <= CMD_NONE;
            cnt <= '0;
        end else begin
            cmd <= nxt_cmd;
            if (nxt == EXITING_SR && state != EXITING_SR) cnt <= exit_hold;
            else if (state == EXITING_SR && cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (state == NORMAL && cmd == CMD_NONE));

    assert_hold_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EXITING_SR && cnt != '0) |=> state == EXITING_SR);

    assert_dpd_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DPD_ENTER) |-> $past(dpd_arm));

    assert_sr_exit_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SR_EXIT) |-> (state == EXITING_SR));

endmodule

// File: rtl/sdram_lp_gate.sv
module sdram_lp_gate
    import sdram_lp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NCS    = 4,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_req,
    input  logic              dp_bit,
    input  logic              clk_en_bit,
    input  logic              clk_ctl_bit,
    input  logic [HOLD_W-1:0] exit_hold,
    input  logic              dyn_busy,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NCS-1:0]    cs_stat,
    output logic [NCS-1:0]    cs_dyn,
    output logic              req_wait,
    output logic              bus_err,
    output logic              sr_ack,
    output logic [2:0]        seq_cmd
);

    logic [NCS-1:0] hit_stat;
    logic [NCS-1:0] hit_dyn;
    logic           dpd_arm;
    logic           in_stat;
    logic           in_dyn;
    logic           dyn_open;
    logic           dyn_hold;
    lp_state_e      state;
    lp_cmd_e        cmd;

    assign dpd_arm = dp_bit & clk_en_bit & clk_ctl_bit;

    lp_addr_decode #(
        .AW  (ADDR_W),
        .NCS (NCS)
    ) u_decode (
        .addr     (req_addr),
        .hit_stat (hit_stat),
        .hit_dyn  (hit_dyn)
    );

    lp_mode_fsm #(
        .HOLD_W (HOLD_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_req    (sr_req),
        .dp_bit    (dp_bit),
        .dpd_arm   (dpd_arm),
        .dyn_busy  (dyn_busy),
        .exit_hold (exit_hold),
        .state     (state),
        .cmd       (cmd)
    );

    assign in_stat  = |hit_stat;
    assign in_dyn   = |hit_dyn;
    assign dyn_open = (state == NORMAL);
    assign dyn_hold = (state == ENTERING_SR) || (state == EXITING_SR);

    always_comb begin
        cs_stat  = req_valid ? hit_stat : '0;
        cs_dyn   = (req_valid && dyn_open) ? hit_dyn : '0;
        req_wait = req_valid && in_dyn && dyn_hold;
        bus_err  = req_valid && ((!in_stat && !in_dyn) ||
                                 (in_dyn && !dyn_open && !dyn_hold));
    end

    assign sr_ack  = (state == SELF_REFRESH);
    assign seq_cmd = cmd;

    assert_closed_no_dyn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack || state == DEEP_PD) |-> cs_dyn == '0);

    assert_ack_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_ack) |-> (!$past(dyn_busy) && seq_cmd == 3'd1));

    assert_err_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (cs_stat == '0 && cs_dyn == '0 && !req_wait));

    assert_wait_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_wait |-> (cs_dyn == '0 && !bus_err));

endmodule

// File: tb/sdram_lp_gate_tb.sv
module sdram_lp_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sr_req, dp_bit, clk_en_bit, clk_ctl_bit, dyn_busy, req_valid;
    logic [7:0]  exit_hold;
    logic [31:0] req_addr;
    logic [3:0]  cs_stat, cs_dyn;
    logic        req_wait, bus_err, sr_ack;
    logic [2:0]  seq_cmd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_lp_gate u_dut (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .dp_bit(dp_bit),
        .clk_en_bit(clk_en_bit), .clk_ctl_bit(clk_ctl_bit), .exit_hold(exit_hold),
        .dyn_busy(dyn_busy), .req_valid(req_valid), .req_addr(req_addr),
        .cs_stat(cs_stat), .cs_dyn(cs_dyn), .req_wait(req_wait), .bus_err(bus_err),
        .sr_ack(sr_ack), .seq_cmd(seq_cmd)
    );

    // gate modes as seen by the bench: 0 open, 1 hold, 2 closed
    function automatic logic [3:0] f_stat(input logic [31:0] a);
        return (a[31:26] == 6'b100000) ? (4'b0001 << a[25:24]) : 4'b0000;
    endfunction

    function automatic logic [3:0] f_dyn(input logic [31:0] a);
        return (a[31:28] >= 4'hA && a[31:28] <= 4'hD) ? (4'b0001 << (a[31:28] - 4'hA)) : 4'b0000;
    endfunction

    // {cs_stat, cs_dyn, wait, err}
    function automatic logic [9:0] f_expect(input logic [31:0] a, input int mode);
        logic [3:0] s, d;
        s = f_stat(a);
        d = f_dyn(a);
        if (s == 0 && d == 0) return {4'b0, 4'b0, 1'b0, 1'b1};
        if (s != 0)           return {s, 4'b0, 1'b0, 1'b0};
        if (mode == 0)        return {4'b0, d, 1'b0, 1'b0};
        if (mode == 1)        return {4'b0, 4'b0, 1'b1, 1'b0};
        return {4'b0, 4'b0, 1'b0, 1'b1};
    endfunction

    function automatic logic [31:0] rand_addr();
        int k;
        k = $urandom_range(0, 2);
        if (k == 0) return {6'b100000, 26'($urandom)};
        if (k == 1) return {4'($urandom_range(10, 13)), 28'($urandom)};
        return {4'($urandom_range(0, 7)), 28'($urandom)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic probe(input logic [31:0] a, input int mode, input string req);
        logic [9:0] e, got;
        req_valid = 1'b1;
        req_addr  = a;
        #2;
        got = {cs_stat, cs_dyn, req_wait, bus_err};
        e   = f_expect(a, mode);
        chk(got == e, req, 32'(got), 32'(e));
        req_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        rst_n = 0; sr_req = 0; dp_bit = 0; clk_en_bit = 0; clk_ctl_bit = 0;
        dyn_busy = 0; req_valid = 0; req_addr = 0; exit_hold = 8'd3;
        tick(); tick();
        // R1 reset state
        chk(sr_ack == 0, "R1 ack", 32'(sr_ack), 0);
        chk(seq_cmd == 0, "R1 cmd", 32'(seq_cmd), 0);
        chk({cs_stat, cs_dyn, req_wait, bus_err} == 0, "R1 idle outputs",
            32'({cs_stat, cs_dyn, req_wait, bus_err}), 0);
        rst_n = 1;
        tick();
        probe(32'hA000_0000, 0, "R1 normal after reset");

        // R2 R3 R4 random decode in NORMAL
        for (int i = 0; i < 150; i++) begin
            tick();
            probe(rand_addr(), 0, "R2/R3/R4 normal decode");
        end
        tick(); probe(32'h83FF_FFFF, 0, "R2 last static");
        tick(); probe(32'h8400_0000, 0, "R4 above static");
        tick(); probe(32'hDFFF_FFFF, 0, "R3 last dynamic");
        tick(); probe(32'hE000_0000, 0, "R4 above dynamic");

        // R10 two of three bits are ignored
        dp_bit = 1; clk_en_bit = 1; clk_ctl_bit = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(seq_cmd == 0, "R10 partial arm cmd", 32'(seq_cmd), 0);
        end
        probe(32'hB000_0040, 0, "R10 partial arm still open");
        dp_bit = 0; clk_en_bit = 0;

        // R5 entry waits for busy back end
        tick();
        dyn_busy = 1; sr_req = 1;
        tick();
        probe(32'hC123_4560, 1, "R6 hold during entry");
        chk(sr_ack == 0, "R5 ack waits", 32'(sr_ack), 0);
        tick(); tick();
        chk(sr_ack == 0 && seq_cmd == 0, "R5 still draining", 32'({sr_ack, seq_cmd}), 0);
        dyn_busy = 0;
        tick();
        chk(seq_cmd == 3'd1, "R5 enter cmd", 32'(seq_cmd), 1);
        chk(sr_ack == 1, "R5 ack", 32'(sr_ack), 1);
        probe(32'hA000_1000, 2, "R7 dyn refused");
        tick();
        chk(seq_cmd == 0, "R11 cmd one cycle", 32'(seq_cmd), 0);

        // R7 R8 random in SELF_REFRESH
        for (int i = 0; i < 60; i++) begin
            tick();
            probe(rand_addr(), 2, "R7/R8 self-refresh decode");
        end

        // R9 exit with hold of 3 -> 4 waiting cycles
        sr_req = 0;
        tick();
        chk(seq_cmd == 3'd2, "R9 exit cmd", 32'(seq_cmd), 2);
        chk(sr_ack == 0, "R9 ack drops", 32'(sr_ack), 0);
        probe(32'hD000_0000, 1, "R9 hold 1");
        for (int i = 0; i < 3; i++) begin
            tick();
            probe(32'hD000_0000, 1, "R9 hold window");
        end
        tick();
        probe(32'hD000_0000, 0, "R9 reopened");

        // R12 simultaneous request, deep power-down wins
        sr_req = 1; dp_bit = 1; clk_en_bit = 1; clk_ctl_bit = 1;
        tick();
        tick();
        chk(seq_cmd == 3'd3, "R12 dpd enter cmd", 32'(seq_cmd), 3);
        chk(sr_ack == 0, "R12 no ack", 32'(sr_ack), 0);
        probe(32'hB000_0000, 2, "R10 dyn refused in dpd");
        for (int i = 0; i < 3; i++) begin
            tick();
            probe(32'h8100_0010, 2, "R8 static in dpd");
        end
        dp_bit = 0; sr_req = 0;
        tick();
        chk(seq_cmd == 3'd4, "R10 dpd exit cmd", 32'(seq_cmd), 4);
        probe(32'hB000_0000, 1, "R10 hold after dpd");
        tick(); tick(); tick(); tick();
        probe(32'hB000_0000, 0, "R10 reopened after dpd");
        clk_en_bit = 0; clk_ctl_bit = 0;

        // R10 from SELF_REFRESH straight into deep power-down
        sr_req = 1;
        tick(); tick();
        chk(sr_ack == 1, "R5 ack second entry", 32'(sr_ack), 1);
        dp_bit = 1; clk_en_bit = 1; clk_ctl_bit = 1;
        tick();
        chk(seq_cmd == 3'd3 && sr_ack == 0, "R10 sr to dpd",
            32'({sr_ack, seq_cmd}), 3);
        dp_bit = 0; clk_en_bit = 0; clk_ctl_bit = 0; sr_req = 0;
        for (int i = 0; i < 6; i++) tick();
        probe(32'hA800_0000, 0, "R10 open after recovery");

        // R13 request withdrawn while draining
        sr_req = 1; dyn_busy = 1;
        tick();
        probe(32'hA000_0000, 1, "R13 draining");
        sr_req = 0; dyn_busy = 0;
        tick();
        chk(seq_cmd == 0 && sr_ack == 0, "R13 no command", 32'({sr_ack, seq_cmd}), 0);
        probe(32'hA000_0000, 0, "R13 back to open");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule